// File: doc/BRIEF.md
# SRAM Audio Delay-Line Controller

This block runs an external asynchronous static RAM as a circular buffer for audio samples. From one master clock it builds a fixed-length sample slot. By default a slot is 256 master clocks, which turns an 11.2896 MHz master clock into a 44.1 kHz sample rate. In every slot it does two things: it reads one delayed sample out of the RAM, then it writes the newest input sample into it. Both accesses share a single address bus and a single bidirectional data bus. The read and write accesses sit in separate windows of the slot, with idle clocks between them, so the RAM strobes never overlap and the data bus never has two drivers.

A write pointer moves forward by one location per slot and wraps at the end of the buffer. The read address is the write pointer minus the programmed delay, taken modulo the buffer depth. With 32768 twelve-bit locations the longest delay is about 743 ms at 44.1 kHz. The block puts out each delayed sample together with a one-clock valid strobe. It returns zero for every slot until the buffer holds enough samples to cover the programmed delay.

Top module: `sram_delay_line`

## Requirements
- R1: One slot lasts exactly SLOT_CLKS master clocks. It contains one read window and one write window, so the output valid strobe pulses once every SLOT_CLKS clocks.
- R2: Slot k writes to address k modulo 2^ADDR_W. The address goes up by one per slot and wraps from all-ones to zero. The pointer is zero after reset.
- R3: During the read window of slot k, the address is (k - D) modulo 2^ADDR_W. D is the delay setting as captured at the start of that slot.
- R4: A delay setting of 0 behaves exactly like a setting of 1.
- R5: The RAM write in slot k stores the input sample captured at the start of slot k. The output of slot k equals the input sample of slot k - D.
- R6: If k < D, the output of slot k is zero. This holds whatever the RAM holds at that address.
- R7: Output enable and write enable are never low in the same clock. Write enable falls at least 3 clocks after output enable rises. The block drives the data bus only while output enable is high.
- R8: The output valid strobe is high for exactly one clock per slot. The output sample changes only on the edge that raises that strobe.
- R9: While reset is high, chip select, write enable and output enable are all high, the valid strobe is low, the output sample is zero, and the data bus is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | SAMPLE_W | New audio sample, captured at the start of each slot |
| delaySet | input | ADDR_W | Delay length in slots, captured at the start of each slot |
| sampleOut | output | SAMPLE_W | Delayed audio sample |
| outValid | output | 1 | One-clock strobe that marks a new sampleOut |
| sramAddr | output | ADDR_W | RAM address |
| sramData | inout | SAMPLE_W | RAM data bus, driven only during the write window |
| sramCsN | output | 1 | RAM chip select, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramOeN | output | 1 | RAM output enable, active low |

## Verification
The assertions assume that the RAM drives the data bus only while chip select and output enable are both low. They also assume that reset is held for at least one clock before the first slot begins. The bench's RAM model obeys exactly that rule and starts filled with a nonzero pattern, so a missing zero-fill shows up as a mismatch. The bench changes sampleIn and delaySet only right after a valid strobe, which keeps both inputs steady across the slot-start capture. It runs past the buffer wrap and through the zero, smallest and largest delay settings.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // strobes from sequencer to datapath, all aligned with the current phase
  typedef struct packed {
    logic latchIn;   // slot start: capture input sample and delay
    logic capture;   // last read clock: register the RAM data
    logic advance;   // last write clock: step the write pointer
    logic selWrite;  // address mux picks the write pointer
    logic driveBus;  // enable the data bus driver
  } dlyStrobes_t;
endpackage

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int SLOT_CLKS = 256,
  parameter int RD_LEN    = 4,
  parameter int IDLE_CLKS = 2,
  parameter int WR_LEN    = 4
) (
  input  logic        clk,
  input  logic        rst,
  output dlyStrobes_t str,
  output logic        csN,
  output logic        weN,
  output logic        oeN
);
  localparam int PH_W     = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam int RD_FIRST = 1;
  localparam int RD_LAST  = RD_FIRST + RD_LEN - 1;
  localparam int WR_FIRST = RD_LAST + IDLE_CLKS + 1;
  localparam int WR_LAST  = WR_FIRST + WR_LEN - 1;
  localparam logic [PH_W-1:0] PH_MAX = PH_W'(SLOT_CLKS - 1);

  logic [PH_W-1:0] phase, phaseNext;
  logic            rdNext, wrNext, weNext;
  logic            selWriteQ, driveBusQ;

  always_comb begin
    phaseNext = (phase == PH_MAX) ? '0 : phase + 1'b1;
    rdNext = (phaseNext >= PH_W'(RD_FIRST)) && (phaseNext <= PH_W'(RD_LAST));
    wrNext = (phaseNext >= PH_W'(WR_FIRST)) && (phaseNext <= PH_W'(WR_LAST));
    // write enable sits one clock inside the bus-drive window on each side
    weNext = (phaseNext > PH_W'(WR_FIRST)) && (phaseNext < PH_W'(WR_LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      csN       <= 1'b1;
      oeN       <= 1'b1;
      weN       <= 1'b1;
      selWriteQ <= 1'b0;
      driveBusQ <= 1'b0;
    end else begin
      phase     <= phaseNext;
      csN       <= !(rdNext || wrNext);
      oeN       <= !rdNext;
      weN       <= !weNext;
      selWriteQ <= wrNext;
      driveBusQ <= wrNext;
    end
  end

  always_comb begin
    str.latchIn  = (phase == '0);
    str.capture  = (phase == PH_W'(RD_LAST));
    str.advance  = (phase == PH_W'(WR_LAST));
    str.selWrite = selWriteQ;
    str.driveBus = driveBusQ;
  end
endmodule

// File: rtl/dly_path.sv
module dly_path
  import dly_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ADDR_W   = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  dlyStrobes_t         str,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [ADDR_W-1:0]   delaySet,
  input  logic [SAMPLE_W-1:0] busIn,
  output logic [SAMPLE_W-1:0] busOut,
  output logic [ADDR_W-1:0]   addr,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                outValid
);
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FILLED = '1;

  logic [ADDR_W-1:0]   wPtr, delayReg, written, rdAddr;
  logic [SAMPLE_W-1:0] inReg;

  assign rdAddr = wPtr - delayReg;
  assign addr   = str.selWrite ? wPtr : rdAddr;
  assign busOut = inReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      wPtr      <= '0;
      delayReg  <= ONE;
      written   <= '0;
      inReg     <= '0;
      sampleOut <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= str.capture;
      if (str.latchIn) begin
        inReg    <= sampleIn;
        delayReg <= (delaySet == '0) ? ONE : delaySet;
      end
      if (str.capture)
        sampleOut <= (written >= delayReg) ? busIn : '0;
      if (str.advance) begin
        wPtr <= wPtr + ONE;
        if (written != FILLED) written <= written + ONE;
      end
    end
  end
endmodule

// File: rtl/sram_delay_line.sv
module sram_delay_line
  import dly_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int ADDR_W    = 15,
  parameter int SLOT_CLKS = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [ADDR_W-1:0]   delaySet,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                outValid,
  output logic [ADDR_W-1:0]   sramAddr,
  inout  wire  [SAMPLE_W-1:0] sramData,
  output logic                sramCsN,
  output logic                sramWeN,
  output logic                sramOeN
);
  dlyStrobes_t         str;
  logic [SAMPLE_W-1:0] busOut;

  dly_ctrl #(.SLOT_CLKS(SLOT_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .str(str),
    .csN(sramCsN), .weN(sramWeN), .oeN(sramOeN)
  );

  dly_path #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rst(rst), .str(str),
    .sampleIn(sampleIn), .delaySet(delaySet),
    .busIn(sramData), .busOut(busOut), .addr(sramAddr),
    .sampleOut(sampleOut), .outValid(outValid)
  );

  assign sramData = str.driveBus ? busOut : 'z;
endmodule

// File: rtl/dly_checker.sv
module dly_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              csN,
  input logic              weN,
  input logic              oeN,
  input logic              busDrive,
  input logic              outValid,
  input logic [ADDR_W-1:0] addr
);
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(!oeN && !weN));
  p_we_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(weN) |-> ($past(oeN, 1) && $past(oeN, 2) && $past(oeN, 3)));
  p_bus_free_r7: assert property (@(posedge clk) disable iff (rst)
    !oeN |-> !busDrive);
  p_we_in_cs_r7: assert property (@(posedge clk) disable iff (rst)
    !weN |-> !csN);
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!csN && $past(!csN)) |-> $stable(addr));
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);
  p_reset_idle_r9: assert property (@(posedge clk)
    $past(rst) |-> (csN && weN && oeN && !outValid));
endmodule

bind sram_delay_line dly_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .csN(sramCsN), .weN(sramWeN), .oeN(sramOeN),
  .busDrive(str.driveBus), .outValid(outValid), .addr(sramAddr)
);

// File: tb/tb_sram_delay_line.sv
module tb_sram_delay_line;
  localparam int SW     = 12;
  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;
  localparam int SLOT   = 32;
  localparam int NSLOTS = 300;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [SW-1:0] sampleIn = '0;
  logic [AW-1:0] delaySet = '0;
  logic [SW-1:0] sampleOut;
  logic          outValid;
  logic [AW-1:0] sramAddr;
  wire  [SW-1:0] sramData;
  logic          sramCsN, sramWeN, sramOeN;

  sram_delay_line #(.SAMPLE_W(SW), .ADDR_W(AW), .SLOT_CLKS(SLOT)) dut (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .delaySet(delaySet),
    .sampleOut(sampleOut), .outValid(outValid), .sramAddr(sramAddr),
    .sramData(sramData), .sramCsN(sramCsN), .sramWeN(sramWeN), .sramOeN(sramOeN)
  );

  always #5 clk = ~clk;

  // asynchronous RAM model
  logic [SW-1:0] mem [DEPTH];
  assign sramData = (!sramCsN && !sramOeN) ? mem[sramAddr] : 'z;
  always @(posedge sramWeN) if (!sramCsN) mem[sramAddr] <= sramData;

  int checks = 0, errors = 0, cyc = 0;
  logic [SW-1:0] sArr [NSLOTS];
  int            dArr [NSLOTS];
  logic [SW-1:0] expQ [$];
  string         tagQ [$];
  logic          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int dEff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int pickDelay(input int k);
    if (k < 80)  return 5;
    if (k < 160) return 0;    // R4: clamps to 1
    if (k < 240) return DEPTH - 1;
    return 20;
  endfunction

  // driver: sets the inputs for slot k and pushes its expected output
  task automatic driveSlot(input int k);
    int de;
    sArr[k] = SW'((k * 173) ^ 12'hA5A);
    if (k % 50 == 7) sArr[k] = '1;
    if (k % 50 == 9) sArr[k] = '0;
    dArr[k]  = pickDelay(k);
    sampleIn = sArr[k];
    delaySet = AW'(dArr[k]);
    de = dEff(dArr[k]);
    if (k < de) begin expQ.push_back('0); tagQ.push_back("R6"); end
    else begin
      expQ.push_back(sArr[k - de]);
      tagQ.push_back(dArr[k] == 0 ? "R4" : "R5");
    end
  endtask

  // monitor
  int  wrIdx = 0, rdIdx = 0, nValid = 0, lastValid = 0;
  logic prevWe = 1'b1, prevOe = 1'b1, prevValid = 1'b0;
  logic [SW-1:0] heldOut = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prevWe && !sramWeN) begin
        chk(sramAddr == AW'(wrIdx), "R2", int'(sramAddr), wrIdx % DEPTH);
        chk(sramData === sArr[wrIdx], "R5", int'(sramData), int'(sArr[wrIdx]));
        chk(sramOeN == 1'b1, "R7", int'(sramOeN), 1);
        wrIdx++;
      end
      if (prevOe && !sramOeN) begin
        chk(sramAddr == AW'(rdIdx - dEff(dArr[rdIdx])), "R3", int'(sramAddr),
            (rdIdx - dEff(dArr[rdIdx])) & (DEPTH - 1));
        rdIdx++;
      end
      if (!sramOeN && !sramWeN) chk(1'b0, "R7", 0, 1);
      if (prevValid) chk(!outValid, "R8", int'(outValid), 0);
      if (!outValid && sampleOut != heldOut) chk(1'b0, "R8", int'(sampleOut), int'(heldOut));
      if (outValid) begin
        logic [SW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(sampleOut == e, t, int'(sampleOut), int'(e));
        if (nValid > 0) chk(cyc - lastValid == SLOT, "R1", cyc - lastValid, SLOT);
        lastValid = cyc;
        nValid++;
        heldOut = sampleOut;
      end
      prevWe = sramWeN; prevOe = sramOeN; prevValid = outValid;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = SW'(12'h3C1 + i);  // nonzero fill for R6
    driveSlot(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: idle outputs under reset
    chk(sramCsN && sramWeN && sramOeN, "R9", {sramCsN, sramWeN, sramOeN}, 7);
    chk(!outValid, "R9", int'(outValid), 0);
    chk(sampleOut == '0, "R9", int'(sampleOut), 0);
    chk(sramData === 'z, "R9", int'(sramData), 0);
    rst = 1'b0;
    for (int k = 1; k < NSLOTS; k++) begin
      @(negedge clk);
      while (!outValid) @(negedge clk);
      driveSlot(k);
    end
    @(negedge clk);
    while (!outValid) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(nValid == NSLOTS, "R1", nValid, NSLOTS);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 20000) @(posedge clk);
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule